// File: doc/BRIEF.md
# Triangle Counter A/D Trigger Generator

The block runs a 16-bit counter as a triangle wave for center-aligned PWM. The counter climbs by one per clock from zero to a programmed period, then falls by one per clock back to zero, and repeats. From this counter it derives one A/D conversion trigger line. An 8-bit enable word selects which timing events may drive that line. Three events are compare matches, and each compare value can fire on the rising slope, the falling slope or both. Two more events are the turning points at the top and the bottom of the wave.

Turning-point events pass through a thinning stage before they can raise the trigger. The stage lets one event out of every N+1 through, with N from 0 to 15. The thinned events also appear on two flag outputs, for use as interrupt sources. A mode input selects the high-accuracy triangle mode. Only in that mode do the falling-slope match enables and the bottom-turn enable have any effect.

All enabled events are merged onto the trigger line. Every output is a single-cycle level derived from registered state. The block has no data stream, so no valid/ready handshake is involved. All pins are plain control and status signals.

Top module: `tri_adc_trig`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `trig`, `top_evt` and `bot_evt` are 0. The counter leaves reset at 0, counting upward.
- R2: The counter steps +1 per clock until it reaches `period`, then −1 per clock down to 0, and repeats. The value `period` must be at least 1. The cycle in which the counter sits at `period` is a top-turn event. The cycle in which it returns to 0 is a bottom-turn event. The zero at start-up is not a bottom-turn event.
- R3: The top-turn thinning counter starts at 0 after reset. On each top turn, if the counter is greater than or equal to `skip_n`, `top_evt` pulses and the counter clears; otherwise the counter increments and no pulse is produced. With a steady `skip_n` = N, the pulse therefore occurs on turns N+1, 2(N+1), and so on.
- R4: Bottom turns are thinned the same way onto `bot_evt`, with their own counter that is independent of the top-turn counter.
- R5: Compare value k is held in `cmp_vals[16k+15:16k]`, for k = 0, 1, 2. Enable bit 2+2k fires `trig` in any cycle where the counter equals compare value k and the last step was upward.
- R6: Enable bit 3+2k fires `trig` when the counter equals compare value k and the last step was downward. This applies only while `hiacc` is 1; while `hiacc` is 0 these bits have no effect.
- R7: Enable bit 1 fires `trig` in every cycle where `top_evt` is 1, in either mode.
- R8: Enable bit 0 fires `trig` in every cycle where `bot_evt` is 1. This applies only while `hiacc` is 1.
- R9: A compare value equal to `period` counts as an upward match, once per top turn. A compare value of 0 counts as a downward match, once per bottom turn. No match is taken in the first cycle after reset.
- R10: `trig` is the OR of all enabled events. When several events coincide, `trig` is high for that one cycle only.
- R11: A compare value greater than `period` never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period | input | 16 | Top value of the triangle (≥1) |
| cmp_vals | input | 48 | Three compare values; value k in bits 16k+15:16k |
| trig_en | input | 8 | Event enables: bit 0 bottom, bit 1 top, bits 2+2k and 3+2k for the up and down matches of compare k |
| hiacc | input | 1 | High-accuracy triangle mode select |
| skip_n | input | 4 | Turning-point thinning count N |
| trig | output | 1 | A/D conversion trigger pulse |
| top_evt | output | 1 | Thinned top-turn event |
| bot_evt | output | 1 | Thinned bottom-turn event |

## Verification
Two cases are hard to reach and need deliberate stimulus. The first is a compare value sitting exactly on a turning value: it must match once, in the direction of arrival. The second is a turning-point trigger that the thinning stage suppresses on some turns and lets through on others.

The bench uses a short period, so turns come every few cycles, and places compare values at 0, at `period` and above it. It sweeps `skip_n` across 0, 2 and a mid-run decrease, with both turn enables set. It also toggles `hiacc` while the falling-slope enables stay set, so that ignored enables are seen at `trig`. A behavioural model tracks the counter, the slope and both thinning counts, and predicts all three outputs every cycle.

// File: rtl/tatg_pkg.sv
package tatg_pkg;
  localparam int unsigned EN_BOT   = 0;
  localparam int unsigned EN_TOP   = 1;
  localparam int unsigned EN_MBASE = 2;

  typedef enum logic {SLOPE_DOWN = 1'b0, SLOPE_UP = 1'b1} slope_e;

  function automatic int unsigned en_up_bit(input int unsigned k);
    return EN_MBASE + 2 * k;
  endfunction

  function automatic int unsigned en_dn_bit(input int unsigned k);
    return EN_MBASE + 2 * k + 1;
  endfunction
endpackage

// File: rtl/tatg_counter.sv
module tatg_counter
  import tatg_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output slope_e        arr_slope,
  output logic          run,
  output logic          top_raw,
  output logic          bot_raw
);
  slope_e      head;
  logic [CW:0] nxt_up;
  logic        hit_top;
  logic        hit_bot;

  assign nxt_up  = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign hit_top = (nxt_up >= {1'b0, period});
  assign hit_bot = (cnt == {{(CW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      head      <= SLOPE_UP;
      arr_slope <= SLOPE_UP;
      run       <= 1'b0;
      top_raw   <= 1'b0;
      bot_raw   <= 1'b0;
    end else begin
      run <= 1'b1;
      if (head == SLOPE_UP) begin
        cnt       <= nxt_up[CW-1:0];
        arr_slope <= SLOPE_UP;
        top_raw   <= hit_top;
        bot_raw   <= 1'b0;
        head      <= hit_top ? SLOPE_DOWN : SLOPE_UP;
      end else begin
        cnt       <= cnt - {{(CW-1){1'b0}}, 1'b1};
        arr_slope <= SLOPE_DOWN;
        top_raw   <= 1'b0;
        bot_raw   <= hit_bot;
        head      <= hit_bot ? SLOPE_UP : SLOPE_DOWN;
      end
    end
  end

  // R2: every clock out of reset moves the counter by exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt == CW'($past(cnt) + 1'b1)) || (cnt == CW'($past(cnt) - 1'b1)));

  // R2: a top turn is reached going up and leaves going down
  assert_top_turn_R2: assert property (@(posedge clk) disable iff (rst)
    top_raw |-> (arr_slope == SLOPE_UP) && (head == SLOPE_DOWN));

  // R2: a bottom turn sits at zero, reached going down
  assert_bot_turn_R2: assert property (@(posedge clk) disable iff (rst)
    bot_raw |-> (cnt == '0) && (arr_slope == SLOPE_DOWN) && (head == SLOPE_UP));
endmodule

// File: rtl/tatg_skip.sv
module tatg_skip #(
  parameter int unsigned SKW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           raw,
  input  logic [SKW-1:0] skip_n,
  output logic           pass
);
  logic [SKW-1:0] seen;

  assign pass = raw && (seen >= skip_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
    end else if (raw) begin
      seen <= pass ? '0 : seen + 1'b1;
    end
  end

  // R3 (and R4 for the bottom instance): a passed event restarts the count
  assert_skip_clear_R3: assert property (@(posedge clk) disable iff (rst)
    pass |=> (seen == '0));

  // R3: without a turning event the count holds
  assert_skip_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !raw |=> $stable(seen));
endmodule

// File: rtl/tatg_match.sv
module tatg_match
  import tatg_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned NCMP = 3
) (
  input  logic [CW-1:0]      cnt,
  input  slope_e             arr_slope,
  input  logic               run,
  input  logic [NCMP*CW-1:0] cmp_vals,
  input  logic [NCMP-1:0]    en_up,
  input  logic [NCMP-1:0]    en_dn,
  input  logic               hiacc,
  output logic               hit
);
  logic [NCMP-1:0] up_hit;
  logic [NCMP-1:0] dn_hit;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    logic eq;
    assign eq        = run && (cnt == cmp_vals[k*CW +: CW]);
    assign up_hit[k] = eq && (arr_slope == SLOPE_UP) && en_up[k];
    assign dn_hit[k] = eq && (arr_slope == SLOPE_DOWN) && en_dn[k] && hiacc;
  end

  assign hit = (|up_hit) || (|dn_hit);
endmodule

// File: rtl/tri_adc_trig.sv
module tri_adc_trig
  import tatg_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned NCMP = 3,
  parameter int unsigned SKW  = 4,
  localparam int unsigned ENW = EN_MBASE + 2 * NCMP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      period,
  input  logic [NCMP*CW-1:0] cmp_vals,
  input  logic [ENW-1:0]     trig_en,
  input  logic               hiacc,
  input  logic [SKW-1:0]     skip_n,
  output logic               trig,
  output logic               top_evt,
  output logic               bot_evt
);
  logic [CW-1:0]   cnt;
  slope_e          arr_slope;
  logic            run;
  logic            top_raw;
  logic            bot_raw;
  logic            match_hit;
  logic [NCMP-1:0] en_up;
  logic [NCMP-1:0] en_dn;

  for (genvar k = 0; k < NCMP; k++) begin : g_en
    assign en_up[k] = trig_en[en_up_bit(k)];
    assign en_dn[k] = trig_en[en_dn_bit(k)];
  end

  tatg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .period(period), .cnt(cnt),
    .arr_slope(arr_slope), .run(run), .top_raw(top_raw), .bot_raw(bot_raw)
  );

  tatg_skip #(.SKW(SKW)) u_skip_top (
    .clk(clk), .rst(rst), .raw(top_raw), .skip_n(skip_n), .pass(top_evt)
  );

  tatg_skip #(.SKW(SKW)) u_skip_bot (
    .clk(clk), .rst(rst), .raw(bot_raw), .skip_n(skip_n), .pass(bot_evt)
  );

  tatg_match #(.CW(CW), .NCMP(NCMP)) u_match (
    .cnt(cnt), .arr_slope(arr_slope), .run(run), .cmp_vals(cmp_vals),
    .en_up(en_up), .en_dn(en_dn), .hiacc(hiacc), .hit(match_hit)
  );

  assign trig = match_hit
             || (top_evt && trig_en[EN_TOP])
             || (bot_evt && trig_en[EN_BOT] && hiacc);

  // R1: nothing fires before the counter has made its first step
  assert_quiet_start_R1: assert property (@(posedge clk) disable iff (rst)
    !run |-> !trig && !top_evt && !bot_evt);

  // R9: the start-up zero is never taken as a match
  assert_no_start_match_R9: assert property (@(posedge clk) disable iff (rst)
    !run |-> !match_hit);

  // R8: outside high-accuracy mode only the top turn can add to the matches
  assert_bot_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!hiacc && !match_hit) |-> (trig == (top_evt && trig_en[EN_TOP])));

  // R2: top and bottom events never share a cycle
  assert_turn_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(top_evt && bot_evt));
endmodule

// File: tb/tb_tri_adc_trig.sv
module tb_tri_adc_trig;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] period;
  logic [15:0] c0, c1, c2;
  logic [47:0] cmp_vals;
  logic [7:0]  trig_en;
  logic        hiacc;
  logic [3:0]  skip_n;
  logic        trig, top_evt, bot_evt;

  assign cmp_vals = {c2, c1, c0};

  always #4 clk = ~clk;

  tri_adc_trig dut (
    .clk(clk), .rst(rst), .period(period), .cmp_vals(cmp_vals),
    .trig_en(trig_en), .hiacc(hiacc), .skip_n(skip_n),
    .trig(trig), .top_evt(top_evt), .bot_evt(bot_evt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_going_up, m_arr_up, m_run, m_top, m_bot, m_tsk, m_bsk;

  task automatic model_reset();
    m_cnt = 0; m_going_up = 1; m_arr_up = 1; m_run = 0;
    m_top = 0; m_bot = 0; m_tsk = 0; m_bsk = 0;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic int cmpv(input int k);
    return (k == 0) ? int'(c0) : (k == 1) ? int'(c1) : int'(c2);
  endfunction

  task automatic step(input string tag);
    int e_top, e_bot, e_trig;
    #1;
    e_top  = (m_top && m_tsk >= int'(skip_n)) ? 1 : 0;
    e_bot  = (m_bot && m_bsk >= int'(skip_n)) ? 1 : 0;
    e_trig = 0;
    for (int k = 0; k < 3; k++) begin
      if (m_run && m_cnt == cmpv(k)) begin
        if (m_arr_up && trig_en[2 + 2*k]) e_trig = 1;
        if (!m_arr_up && hiacc && trig_en[3 + 2*k]) e_trig = 1;
      end
    end
    if (e_top && trig_en[1]) e_trig = 1;
    if (e_bot && trig_en[0] && hiacc) e_trig = 1;
    check(tag, "top_evt", int'(top_evt), e_top);
    check(tag, "bot_evt", int'(bot_evt), e_bot);
    check(tag, "trig", int'(trig), e_trig);
    @(posedge clk);
    if (rst) begin
      model_reset();
    end else begin
      if (m_top) m_tsk = e_top ? 0 : m_tsk + 1;
      if (m_bot) m_bsk = e_bot ? 0 : m_bsk + 1;
      m_run = 1;
      if (m_going_up) begin
        m_cnt = m_cnt + 1; m_arr_up = 1; m_bot = 0;
        m_top = (m_cnt >= int'(period)) ? 1 : 0;
        m_going_up = m_top ? 0 : 1;
      end else begin
        m_cnt = m_cnt - 1; m_arr_up = 0; m_top = 0;
        m_bot = (m_cnt == 0) ? 1 : 0;
        m_going_up = m_bot ? 1 : 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic run_n(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    run_n(tag, 3);
    rst = 1'b0;
  endtask

  initial begin
    int seen;
    rst = 1'b1; period = 16'd5; c0 = 16'd0; c1 = 16'd0; c2 = 16'd0;
    trig_en = 8'h00; hiacc = 1'b0; skip_n = 4'd0;
    model_reset();
    @(posedge clk); @(negedge clk);

    // R1: quiet during reset and in the first free cycle
    run_n("R1", 3);
    rst = 1'b0;
    trig_en = 8'hFF; hiacc = 1'b1;
    run_n("R1", 1);
    trig_en = 8'h00;

    // R2: turning events follow the triangle
    do_reset("R2");
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (top_evt) seen++;
      step("R2");
    end
    check("R2", "top turns in 30 cycles", seen, 3);

    // R5: rising-slope matches on all three compare values
    do_reset("R5");
    c0 = 16'd2; c1 = 16'd3; c2 = 16'd4; trig_en = 8'b0101_0100;
    run_n("R5", 30);

    // R6: falling-slope enables ignored, then honoured in high-accuracy mode
    trig_en = 8'b1010_1000; hiacc = 1'b0;
    run_n("R6", 25);
    hiacc = 1'b1;
    run_n("R6", 25);

    // R9: compare values sitting on the turning values
    do_reset("R9");
    c0 = 16'd5; c1 = 16'd0; c2 = 16'd5; trig_en = 8'b0011_1100; hiacc = 1'b1;
    run_n("R9", 30);
    hiacc = 1'b0;
    run_n("R9", 20);

    // R11: compare beyond the top never matches
    c0 = 16'd6; c1 = 16'd200; c2 = 16'd9; trig_en = 8'hFC; hiacc = 1'b1;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (trig) seen++;
      step("R11");
    end
    check("R11", "pulses beyond top", seen, 0);

    // R7 and R8: turning-point triggers, with and without high-accuracy mode
    c0 = 16'd200; c1 = 16'd200; c2 = 16'd200;
    trig_en = 8'b0000_0011; hiacc = 1'b0;
    run_n("R7", 25);
    hiacc = 1'b1;
    run_n("R8", 25);

    // R3 and R4: thinning of turn events
    do_reset("R3");
    skip_n = 4'd2;
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (top_evt) seen++;
      step("R3");
    end
    check("R3", "passed top turns of 6", seen, 2);
    skip_n = 4'd1;
    run_n("R4", 40);
    period = 16'd2; skip_n = 4'd3;
    run_n("R4", 40);

    // R10: coincident events give one pulse
    do_reset("R10");
    period = 16'd4; skip_n = 4'd0;
    c0 = 16'd4; c1 = 16'd4; c2 = 16'd0; trig_en = 8'hFF; hiacc = 1'b1;
    run_n("R10", 30);
    period = 16'd1;
    run_n("R10", 12);
    period = 16'd9; c1 = 16'd3;
    run_n("R10", 40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule